// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block keeps the timing state of one DDR3-style memory channel: per bank, per rank and for the shared column path. Every cycle a scheduler can put one candidate command (row open, row close, column read or column write) to a chosen rank and bank on the query port. The block answers one cycle later with a flag that says whether the candidate could have been issued in the query cycle. The block bases the answer on the commands already issued. Commands that are actually sent to the DRAM are reported back through an issue port. That port updates a set of saturating down-counters and a short per-rank history of recent activations.

Two issue ports exist so that two scheduler paths can share the checker. The channel accepts at most one command per cycle. Port A has priority. When both ports strobe in the same cycle, the port B command is dropped and an error flag is raised. All spacings are compile-time parameters. The defaults are the usual 800 MHz DDR3 values. The per-rank activation history makes sure that a fifth activation inside the rolling window is refused even when the activate-to-activate spacing is already met.

Top module: `dram_timing_chk`

## Requirements
- R1: After reset, `q_ok` and `iss_err` are 0, and every command to every rank and bank is reported legal.
- R2: Command encoding is 0 = ACT, 1 = PRE, 2 = RD, 3 = WR. `q_ok` is registered: it reflects the query of the previous cycle and is 0 when `q_vld` was low.
- R3: A RD or WR to a bank is legal no sooner than 11 cycles after that bank's ACT. Other banks are unaffected.
- R4: An ACT to a bank is legal no sooner than 11 cycles after a PRE to it, and no sooner than 39 cycles after its previous ACT.
- R5: A PRE to a bank is legal no sooner than 28 cycles after its ACT, and no sooner than 6 cycles after a RD to it.
- R6: A PRE to a bank is legal no sooner than 21 cycles after a WR to it: a 5-cycle write latency, a 4-cycle burst and 12 cycles of write recovery.
- R7: Two ACTs to the same rank are at least 5 cycles apart. An ACT to another rank is not delayed by this rule.
- R8: An ACT to a rank is illegal while four ACTs to that rank were issued within the last 32 cycles, even when R7 is met. Other ranks are unaffected.
- R9: Any two column commands on the channel are at least 4 cycles apart.
- R10: A RD to a rank is legal no sooner than 15 cycles after a WR to that rank: 5 plus 4 plus a 6-cycle turnaround. A RD to another rank is not delayed by this rule.
- R11: A column command to a rank other than the one of the last column command needs at least 6 cycles after it: the 4-cycle burst plus a 2-cycle rank gap.
- R12: When both issue ports strobe in one cycle, only port A's command updates the timing state. `iss_err` is 1 in the next cycle, and 0 after any cycle with at most one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_a_vld | input | 1 | Port A issue strobe (priority) |
| iss_a_cmd | input | 2 | Port A command type |
| iss_a_rank | input | RKW | Port A rank |
| iss_a_bank | input | BKW | Port A bank |
| iss_b_vld | input | 1 | Port B issue strobe |
| iss_b_cmd | input | 2 | Port B command type |
| iss_b_rank | input | RKW | Port B rank |
| iss_b_bank | input | BKW | Port B bank |
| q_vld | input | 1 | Candidate query valid |
| q_cmd | input | 2 | Candidate command type |
| q_rank | input | RKW | Candidate rank |
| q_bank | input | BKW | Candidate bank |
| q_ok | output | 1 | Candidate of previous cycle was legal |
| iss_err | output | 1 | Two strobes arrived in the previous cycle |

## Verification
The hardest case to reach is the rolling activation window. The bench has to place four activations to one rank exactly at the activate-to-activate spacing, so that the fifth candidate passes that spacing but still falls inside the window. The stimulus issues ACTs at cycles 0, 5, 10 and 15 to distinct banks. It then queries a fifth bank at cycle 20, 31 and 32, and probes another rank in the same stretch. Each boundary is tested as a pair of queries: one cycle before the limit and exactly at the limit.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_PRE = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } dram_cmd_e;
endpackage

// File: rtl/dtc_downcnt.sv
// Saturating down-counter; each load raises the count to at least its value.
module dtc_downcnt #(
  parameter int CW  = 8,
  parameter int NLD = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NLD-1:0]          ld,
  input  logic [NLD-1:0][CW-1:0]  val,
  output logic                    done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
    for (int i = 0; i < NLD; i++) begin
      if (ld[i] && (val[i] > cnt_d)) cnt_d = val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/dtc_bank_tmr.sv
// Per-bank spacing: row open, row close and column readiness.
module dtc_bank_tmr #(
  parameter int CW      = 8,
  parameter int T_RCD   = 11,
  parameter int T_RP    = 11,
  parameter int T_RC    = 39,
  parameter int T_RAS   = 28,
  parameter int T_RTP   = 6,
  parameter int T_CWD   = 5,
  parameter int T_BURST = 4,
  parameter int T_WR    = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic pre,
  input  logic rd,
  input  logic wr,
  output logic act_rdy,
  output logic pre_rdy,
  output logic col_rdy
);
  localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RTP = CW'(T_RTP - 1);
  localparam logic [CW-1:0] LD_WRP = CW'(T_CWD + T_BURST + T_WR - 1);

  dtc_downcnt #(.CW(CW), .NLD(2)) act_cnt_i (
    .clk(clk), .rst(rst), .ld({pre, act}), .val({LD_RP, LD_RC}), .done(act_rdy)
  );

  dtc_downcnt #(.CW(CW), .NLD(1)) col_cnt_i (
    .clk(clk), .rst(rst), .ld(act), .val(LD_RCD), .done(col_rdy)
  );

  dtc_downcnt #(.CW(CW), .NLD(3)) pre_cnt_i (
    .clk(clk), .rst(rst), .ld({wr, rd, act}), .val({LD_WRP, LD_RTP, LD_RAS}),
    .done(pre_rdy)
  );
endmodule

// File: rtl/dtc_rank_tmr.sv
// Per-rank spacing: activate-to-activate, rolling activation window, write-to-read.
module dtc_rank_tmr #(
  parameter int CW      = 8,
  parameter int N_WIN   = 4,
  parameter int T_RRD   = 5,
  parameter int T_FAW   = 32,
  parameter int T_CWD   = 5,
  parameter int T_BURST = 4,
  parameter int T_WTR   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic wr,
  output logic act_rdy,
  output logic rd_rdy
);
  localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);
  localparam logic [CW-1:0] LD_FAW = CW'(T_FAW - 1);
  localparam logic [CW-1:0] LD_WTR = CW'(T_CWD + T_BURST + T_WTR - 1);

  logic rrd_done;
  logic [CW-1:0] win_q [N_WIN];

  dtc_downcnt #(.CW(CW), .NLD(1)) rrd_cnt_i (
    .clk(clk), .rst(rst), .ld(act), .val(LD_RRD), .done(rrd_done)
  );

  dtc_downcnt #(.CW(CW), .NLD(1)) wtr_cnt_i (
    .clk(clk), .rst(rst), .ld(wr), .val(LD_WTR), .done(rd_rdy)
  );

  // Age history of the last N_WIN activations; entry 0 is the newest.
  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    logic [CW-1:0] src;
    if (i == 0) begin : g_head
      assign src = LD_FAW;
    end else begin : g_tail
      assign src = (win_q[i-1] == '0) ? '0 : win_q[i-1] - CW'(1);
    end
    always_ff @(posedge clk) begin
      if (rst)      win_q[i] <= '0;
      else if (act) win_q[i] <= src;
      else if (win_q[i] != '0) win_q[i] <= win_q[i] - CW'(1);
    end
  end

  assign act_rdy = rrd_done && (win_q[N_WIN-1] == '0);
endmodule

// File: rtl/dtc_col_tmr.sv
// Channel-wide column spacing and rank-switch gap on the data bus.
module dtc_col_tmr #(
  parameter int CW      = 8,
  parameter int RKW     = 1,
  parameter int T_CCD   = 4,
  parameter int T_BURST = 4,
  parameter int T_RTRS  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           col,
  input  logic [RKW-1:0] col_rank,
  input  logic [RKW-1:0] q_rank,
  output logic           col_rdy
);
  localparam logic [CW-1:0] LD_CCD = CW'(T_CCD - 1);
  localparam logic [CW-1:0] LD_SW  = CW'(T_BURST + T_RTRS - 1);

  logic ccd_done, sw_done;
  logic [RKW-1:0] last_rank_q;

  dtc_downcnt #(.CW(CW), .NLD(1)) ccd_cnt_i (
    .clk(clk), .rst(rst), .ld(col), .val(LD_CCD), .done(ccd_done)
  );

  dtc_downcnt #(.CW(CW), .NLD(1)) sw_cnt_i (
    .clk(clk), .rst(rst), .ld(col), .val(LD_SW), .done(sw_done)
  );

  always_ff @(posedge clk) begin
    if (rst)      last_rank_q <= '0;
    else if (col) last_rank_q <= col_rank;
  end

  assign col_rdy = ccd_done && (sw_done || (q_rank == last_rank_q));
endmodule

// File: rtl/dram_timing_chk.sv
module dram_timing_chk
  import dtc_pkg::*;
#(
  parameter int N_RANKS = 2,
  parameter int N_BANKS = 8,
  parameter int N_WIN   = 4,
  parameter int T_RCD   = 11,
  parameter int T_RP    = 11,
  parameter int T_RC    = 39,
  parameter int T_RAS   = 28,
  parameter int T_RRD   = 5,
  parameter int T_FAW   = 32,
  parameter int T_CCD   = 4,
  parameter int T_CWD   = 5,
  parameter int T_BURST = 4,
  parameter int T_WTR   = 6,
  parameter int T_WR    = 12,
  parameter int T_RTP   = 6,
  parameter int T_RTRS  = 2,
  localparam int RKW    = (N_RANKS > 1) ? $clog2(N_RANKS) : 1,
  localparam int BKW    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           iss_a_vld,
  input  logic [1:0]     iss_a_cmd,
  input  logic [RKW-1:0] iss_a_rank,
  input  logic [BKW-1:0] iss_a_bank,
  input  logic           iss_b_vld,
  input  logic [1:0]     iss_b_cmd,
  input  logic [RKW-1:0] iss_b_rank,
  input  logic [BKW-1:0] iss_b_bank,
  input  logic           q_vld,
  input  logic [1:0]     q_cmd,
  input  logic [RKW-1:0] q_rank,
  input  logic [BKW-1:0] q_bank,
  output logic           q_ok,
  output logic           iss_err
);
  localparam int NB_TOT = N_RANKS * N_BANKS;
  localparam int IW     = (NB_TOT > 1) ? $clog2(NB_TOT) : 1;
  localparam int MAXD   = T_RC + T_FAW + T_CWD + T_BURST + T_WR + T_WTR;
  localparam int CW     = $clog2(MAXD + 1);

  // Single issue per cycle: port A wins.
  logic           sel_vld;
  dram_cmd_e      sel_cmd;
  logic [RKW-1:0] sel_rank;
  logic [BKW-1:0] sel_bank;

  always_comb begin
    sel_vld  = iss_a_vld || iss_b_vld;
    sel_cmd  = iss_a_vld ? dram_cmd_e'(iss_a_cmd) : dram_cmd_e'(iss_b_cmd);
    sel_rank = iss_a_vld ? iss_a_rank : iss_b_rank;
    sel_bank = iss_a_vld ? iss_a_bank : iss_b_bank;
  end

  logic is_act, is_pre, is_rd, is_wr;
  assign is_act = sel_vld && (sel_cmd == CMD_ACT);
  assign is_pre = sel_vld && (sel_cmd == CMD_PRE);
  assign is_rd  = sel_vld && (sel_cmd == CMD_RD);
  assign is_wr  = sel_vld && (sel_cmd == CMD_WR);

  logic [NB_TOT-1:0]  bk_act_rdy, bk_pre_rdy, bk_col_rdy;
  logic [N_RANKS-1:0] rk_act_rdy, rk_rd_rdy;
  logic               ch_col_rdy;

  for (genvar r = 0; r < N_RANKS; r++) begin : g_rank
    logic rk_hit;
    assign rk_hit = (sel_rank == RKW'(r));

    dtc_rank_tmr #(
      .CW(CW), .N_WIN(N_WIN), .T_RRD(T_RRD), .T_FAW(T_FAW),
      .T_CWD(T_CWD), .T_BURST(T_BURST), .T_WTR(T_WTR)
    ) rank_i (
      .clk(clk), .rst(rst),
      .act(is_act && rk_hit), .wr(is_wr && rk_hit),
      .act_rdy(rk_act_rdy[r]), .rd_rdy(rk_rd_rdy[r])
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic bk_hit;
      assign bk_hit = rk_hit && (sel_bank == BKW'(b));

      dtc_bank_tmr #(
        .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS),
        .T_RTP(T_RTP), .T_CWD(T_CWD), .T_BURST(T_BURST), .T_WR(T_WR)
      ) bank_i (
        .clk(clk), .rst(rst),
        .act(is_act && bk_hit), .pre(is_pre && bk_hit),
        .rd(is_rd && bk_hit), .wr(is_wr && bk_hit),
        .act_rdy(bk_act_rdy[r*N_BANKS+b]),
        .pre_rdy(bk_pre_rdy[r*N_BANKS+b]),
        .col_rdy(bk_col_rdy[r*N_BANKS+b])
      );
    end
  end

  dtc_col_tmr #(
    .CW(CW), .RKW(RKW), .T_CCD(T_CCD), .T_BURST(T_BURST), .T_RTRS(T_RTRS)
  ) col_i (
    .clk(clk), .rst(rst), .col(is_rd || is_wr), .col_rank(sel_rank),
    .q_rank(q_rank), .col_rdy(ch_col_rdy)
  );

  // Legality of the candidate against state built by earlier issues.
  logic [IW-1:0] q_idx;
  logic          legal;
  assign q_idx = IW'(q_rank) * IW'(N_BANKS) + IW'(q_bank);

  always_comb begin
    unique case (dram_cmd_e'(q_cmd))
      CMD_ACT: legal = bk_act_rdy[q_idx] && rk_act_rdy[q_rank];
      CMD_PRE: legal = bk_pre_rdy[q_idx];
      CMD_RD:  legal = bk_col_rdy[q_idx] && ch_col_rdy && rk_rd_rdy[q_rank];
      CMD_WR:  legal = bk_col_rdy[q_idx] && ch_col_rdy;
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ok    <= 1'b0;
      iss_err <= 1'b0;
    end else begin
      q_ok    <= q_vld && legal;
      iss_err <= iss_a_vld && iss_b_vld;
    end
  end
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk #(
  parameter int N_RANKS = 2,
  parameter int N_BANKS = 8,
  localparam int RKW    = (N_RANKS > 1) ? $clog2(N_RANKS) : 1,
  localparam int BKW    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           iss_a_vld,
  input logic [1:0]     iss_a_cmd,
  input logic [RKW-1:0] iss_a_rank,
  input logic [BKW-1:0] iss_a_bank,
  input logic           iss_b_vld,
  input logic           q_vld,
  input logic [1:0]     q_cmd,
  input logic [RKW-1:0] q_rank,
  input logic [BKW-1:0] q_bank,
  input logic           q_ok,
  input logic           iss_err
);
  AST_DUAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (iss_a_vld && iss_b_vld) |=> iss_err); // R12

  AST_SINGLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !(iss_a_vld && iss_b_vld) |=> !iss_err); // R12

  AST_IDLE_QUERY_LOW: assert property (@(posedge clk) disable iff (rst)
    !q_vld |=> !q_ok); // R2

  AST_RRD_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
    (q_vld && q_cmd == 2'd0 && $past(iss_a_vld && iss_a_cmd == 2'd0)
     && q_rank == $past(iss_a_rank)) |=> !q_ok); // R7

  AST_CCD_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
    (q_vld && q_cmd[1] && $past(iss_a_vld && iss_a_cmd[1])) |=> !q_ok); // R9

  AST_RAS_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
    (q_vld && q_cmd == 2'd1 && $past(iss_a_vld && iss_a_cmd == 2'd0)
     && q_rank == $past(iss_a_rank) && q_bank == $past(iss_a_bank)) |=> !q_ok); // R5
endmodule

bind dram_timing_chk dtc_chk #(.N_RANKS(N_RANKS), .N_BANKS(N_BANKS)) chk_i (
  .clk(clk), .rst(rst),
  .iss_a_vld(iss_a_vld), .iss_a_cmd(iss_a_cmd), .iss_a_rank(iss_a_rank),
  .iss_a_bank(iss_a_bank), .iss_b_vld(iss_b_vld),
  .q_vld(q_vld), .q_cmd(q_cmd), .q_rank(q_rank), .q_bank(q_bank),
  .q_ok(q_ok), .iss_err(iss_err)
);

// File: tb/dram_timing_chk_tb_top.sv
`timescale 1ns/1ps
module dram_timing_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RKW = 1;
  localparam int BKW = 3;
  localparam logic [1:0] ACT = 2'd0, PRE = 2'd1, RD = 2'd2, WR = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_a_vld = 1'b0, iss_b_vld = 1'b0, q_vld = 1'b0;
  logic [1:0] iss_a_cmd = '0, iss_b_cmd = '0, q_cmd = '0;
  logic [RKW-1:0] iss_a_rank = '0, iss_b_rank = '0, q_rank = '0;
  logic [BKW-1:0] iss_a_bank = '0, iss_b_bank = '0, q_bank = '0;
  logic q_ok, iss_err;

  int n_checks = 0;
  int n_fail = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_timing_chk dut_i (
    .clk(clk), .rst(rst),
    .iss_a_vld(iss_a_vld), .iss_a_cmd(iss_a_cmd), .iss_a_rank(iss_a_rank), .iss_a_bank(iss_a_bank),
    .iss_b_vld(iss_b_vld), .iss_b_cmd(iss_b_cmd), .iss_b_rank(iss_b_rank), .iss_b_bank(iss_b_bank),
    .q_vld(q_vld), .q_cmd(q_cmd), .q_rank(q_rank), .q_bank(q_bank),
    .q_ok(q_ok), .iss_err(iss_err)
  );

  // Monitor: compares each registered answer against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (q_ok !== e) begin
        n_fail++;
        $display("FAIL %s: q_ok actual=%0b expected=%0b", t, q_ok, e);
      end
    end
  end

  task automatic check_bit(input logic act_v, input logic exp_v, input string t);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act_v, exp_v);
    end
  endtask

  task automatic clear_in();
    iss_a_vld = 1'b0; iss_b_vld = 1'b0; q_vld = 1'b0;
  endtask

  task automatic cyc_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clear_in();
    end
  endtask

  task automatic cyc_issue(input logic [1:0] c, input int r, input int b);
    @(negedge clk);
    clear_in();
    iss_a_vld = 1'b1; iss_a_cmd = c; iss_a_rank = RKW'(r); iss_a_bank = BKW'(b);
  endtask

  task automatic cyc_dual(input int ra, input int ba, input int rb, input int bb);
    @(negedge clk);
    clear_in();
    iss_a_vld = 1'b1; iss_a_cmd = ACT; iss_a_rank = RKW'(ra); iss_a_bank = BKW'(ba);
    iss_b_vld = 1'b1; iss_b_cmd = ACT; iss_b_rank = RKW'(rb); iss_b_bank = BKW'(bb);
  endtask

  task automatic cyc_query(input logic [1:0] c, input int r, input int b,
                           input bit e, input string t);
    @(negedge clk);
    clear_in();
    q_vld = 1'b1; q_cmd = c; q_rank = RKW'(r); q_bank = BKW'(b);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic cyc_noq(input string t);
    @(negedge clk);
    clear_in();
    q_cmd = ACT; q_rank = '0; q_bank = '0;
    exp_q.push_back(1'b0);
    tag_q.push_back(t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state and fresh legality
    check_bit(q_ok, 1'b0, "R1 q_ok after reset");
    check_bit(iss_err, 1'b0, "R1 iss_err after reset");
    cyc_query(ACT, 0, 0, 1'b1, "R1 ACT fresh");
    cyc_query(PRE, 1, 7, 1'b1, "R1 PRE fresh");
    cyc_query(RD, 0, 3, 1'b1, "R1 RD fresh");
    cyc_query(WR, 1, 2, 1'b1, "R1 WR fresh");
    cyc_noq("R2 no query gives 0");
    cyc_idle(2);

    // R3 row-to-column
    do_reset();
    cyc_issue(ACT, 0, 1);
    cyc_query(RD, 0, 2, 1'b1, "R3 other bank free");
    cyc_idle(8);
    cyc_query(RD, 0, 1, 1'b0, "R3 RD at 10");
    cyc_query(RD, 0, 1, 1'b1, "R3 RD at 11");
    cyc_idle(2);

    // R4 / R5 row timing on one bank
    do_reset();
    cyc_issue(ACT, 1, 3);
    cyc_query(PRE, 1, 3, 1'b0, "R5 PRE at 1");
    cyc_idle(25);
    cyc_query(PRE, 1, 3, 1'b0, "R5 PRE at 27");
    cyc_query(PRE, 1, 3, 1'b1, "R5 PRE at 28");
    cyc_issue(PRE, 1, 3);
    cyc_query(ACT, 1, 3, 1'b0, "R4 ACT 1 after PRE");
    cyc_idle(7);
    cyc_query(ACT, 1, 3, 1'b0, "R4 ACT at 38 (row cycle)");
    cyc_query(ACT, 1, 3, 1'b0, "R4 ACT 10 after PRE");
    cyc_query(ACT, 1, 3, 1'b1, "R4 ACT 11 after PRE");
    cyc_idle(2);

    // R5 read-to-precharge
    do_reset();
    cyc_issue(RD, 0, 0);
    cyc_idle(4);
    cyc_query(PRE, 0, 0, 1'b0, "R5 PRE 5 after RD");
    cyc_query(PRE, 0, 0, 1'b1, "R5 PRE 6 after RD");
    cyc_idle(2);

    // R6 write recovery
    do_reset();
    cyc_issue(WR, 0, 0);
    cyc_idle(19);
    cyc_query(PRE, 0, 0, 1'b0, "R6 PRE 20 after WR");
    cyc_query(PRE, 0, 0, 1'b1, "R6 PRE 21 after WR");
    cyc_idle(2);

    // R10 write-to-read
    do_reset();
    cyc_issue(WR, 0, 0);
    cyc_idle(7);
    cyc_query(RD, 1, 0, 1'b1, "R10 other rank RD at 8");
    cyc_idle(5);
    cyc_query(RD, 0, 1, 1'b0, "R10 RD at 14");
    cyc_query(RD, 0, 1, 1'b1, "R10 RD at 15");
    cyc_idle(2);

    // R7 activate spacing in rank
    do_reset();
    cyc_issue(ACT, 0, 0);
    cyc_query(ACT, 1, 0, 1'b1, "R7 other rank ACT");
    cyc_idle(2);
    cyc_query(ACT, 0, 1, 1'b0, "R7 ACT at 4");
    cyc_query(ACT, 0, 1, 1'b1, "R7 ACT at 5");
    cyc_idle(2);

    // R8 rolling activation window
    do_reset();
    cyc_issue(ACT, 0, 0);
    cyc_idle(4);
    cyc_issue(ACT, 0, 1);
    cyc_idle(4);
    cyc_issue(ACT, 0, 2);
    cyc_idle(4);
    cyc_issue(ACT, 0, 3);
    cyc_idle(4);
    cyc_query(ACT, 0, 4, 1'b0, "R8 fifth ACT at 20");
    cyc_query(ACT, 1, 4, 1'b1, "R8 other rank at 21");
    cyc_idle(9);
    cyc_query(ACT, 0, 4, 1'b0, "R8 fifth ACT at 31");
    cyc_query(ACT, 0, 4, 1'b1, "R8 fifth ACT at 32");
    cyc_idle(2);

    // R9 column spacing
    do_reset();
    cyc_issue(RD, 0, 0);
    cyc_idle(2);
    cyc_query(RD, 0, 1, 1'b0, "R9 RD at 3");
    cyc_query(WR, 0, 2, 1'b1, "R9 WR at 4");
    cyc_idle(2);

    // R11 rank switch on the bus
    do_reset();
    cyc_issue(RD, 0, 0);
    cyc_idle(3);
    cyc_query(RD, 0, 1, 1'b1, "R11 same rank at 4");
    cyc_query(WR, 1, 0, 1'b0, "R11 other rank at 5");
    cyc_query(WR, 1, 0, 1'b1, "R11 other rank at 6");
    cyc_idle(2);

    // R12 dual strobe
    do_reset();
    cyc_dual(0, 0, 1, 0);
    cyc_query(ACT, 1, 0, 1'b1, "R12 port B dropped");
    check_bit(iss_err, 1'b1, "R12 iss_err after dual");
    cyc_query(ACT, 0, 0, 1'b0, "R12 port A taken");
    check_bit(iss_err, 1'b0, "R12 iss_err clears");
    cyc_idle(3);

    finish_run();
  end
endmodule